// File: doc/BRIEF.md
# Asynchronous SRAM Access Controller

This block lets clocked logic use a 512K x 16 asynchronous static RAM. A user port takes one single-word request at a time: a 19-bit word address, 16 bits of write data and a write flag. The controller turns each request into an active-low chip-enable, output-enable and write-enable sequence on the memory pins. It drives the shared bidirectional data bus only while a write needs it. A read returns its data together with a one-cycle completion pulse. A write returns only the pulse.

Each wait length is a whole number of clock cycles. It is derived at elaboration from the clock period and from the memory's nanosecond limits: access time, output-enable access, write pulse width, data setup, address-to-end-of-write, cycle times and output turn-off. Each limit is divided by the period and rounded up, with a floor of one cycle.

Request handshake: a request moves when `req_valid` and `req_ready` are both high at a rising edge. `req_ready` is high only while the controller is idle, so back-pressure lasts from acceptance up to and including the cycle before the completion pulse. The requester may change or drop its fields once the request is accepted.

Top module: `asram_ctrl`

## Requirements
- R1: After reset, `req_ready` is high, `rsp_done` is low, all three memory enables are high and the controller does not drive the data bus.
- R2: A request is accepted on a rising edge where `req_valid` and `req_ready` are both high. `req_ready` stays low from acceptance until the cycle in which `rsp_done` is high, and is high in that cycle.
- R3: A read holds chip enable and output enable low for RD_CYC cycles. RD_CYC is the largest of the rounded read-cycle, address-access and output-enable-access limits, which gives 3 at a 4 ns period. The data bus is sampled at the edge that ends this window and appears on `rsp_rdata` with `rsp_done`, which is high for exactly one cycle, RD_CYC+1 cycles after acceptance.
- R4: During a write, output enable stays high. Write enable stays low for WL_CYC cycles, the largest of the rounded pulse-width, data-setup and address-to-end limits and the rounded write-cycle limit minus one (2 at 4 ns). `rsp_done` follows WL_CYC+2 cycles after acceptance.
- R5: The controller drives the data bus only while write enable is low and for one hold cycle after it rises, and never while the memory may still be driving.
- R6: When a write follows a read, TA_CYC extra cycles are inserted before write enable falls. TA_CYC is the rounded output turn-off limit (1 at 4 ns). During these cycles no enable is low and nothing drives the bus, so that write completes WL_CYC+TA_CYC+2 cycles after acceptance.
- R7: The memory address and write data are captured at acceptance and held stable until the completion pulse, whatever the user port does meanwhile.
- R8: Each wait count equals its nanosecond limit divided by the clock period, rounded up, and is at least one cycle. Under these counts the memory's access, pulse, setup and cycle-time limits are all met.
- R9: A write leaves `rsp_rdata` unchanged from the last completed read.
- R10: Data written to an address is returned by every later read of that address until it is overwritten.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller idle; request accepted on this edge if valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 19 | Word address |
| req_wdata | input | 16 | Write data |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 16 | Data of the last completed read |
| sram_addr | output | 19 | Memory address pins |
| sram_dq | inout | 16 | Shared memory data bus |
| sram_ce_n | output | 1 | Memory chip enable, active low |
| sram_oe_n | output | 1 | Memory output enable, active low |
| sram_we_n | output | 1 | Memory write enable, active low |

## Verification
The hardest situation to reach is the switch from a read to a write. There the memory's output drivers are still turning off while the controller wants to take the bus, and a missing gap only shows as contention or a one-cycle-short latency. The behavioural memory in the bench keeps driving for a full cycle after output enable rises. It drives corrupted data until the access time has passed, and it checks pulse width, setup and address stability on every write. Random operation mixes over a small address pool produce many read-to-write, write-to-read and same-address sequences. Directed pairs add the boundary addresses and the all-zero and all-one data words.

// File: rtl/asram_pkg.sv
package asram_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_TURN,
    ST_READ,
    ST_WRITE,
    ST_HOLD
  } asram_st_e;

  // Whole cycles covering a nanosecond limit, never fewer than one.
  function automatic int ns2cyc(input int lim_ns, input int per_ns);
    int c;
    c = (lim_ns + per_ns - 1) / per_ns;
    return (c < 1) ? 1 : c;
  endfunction

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/asram_wait_cnt.sv
module asram_wait_cnt #(
  parameter int CW = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  output logic          zero
);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             cnt_q <= '0;
    else if (load)          cnt_q <= load_val;
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign zero = (cnt_q == '0);

endmodule

// File: rtl/asram_seq.sv
module asram_seq
  import asram_pkg::*;
#(
  parameter int CW    = 2,
  parameter int RD_LD = 2,
  parameter int WL_LD = 1,
  parameter int TA_LD = 0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic          req_write,
  input  logic          cnt_zero,
  output logic          req_ready,
  output logic          lat_en,
  output logic          cap_en,
  output logic          cnt_load,
  output logic [CW-1:0] cnt_val,
  output logic          ce_n,
  output logic          oe_n,
  output logic          we_n,
  output logic          drv,
  output logic          done
);

  asram_st_e st_q;
  logic      prev_rd_q;

  assign req_ready = (st_q == ST_IDLE);
  assign lat_en    = req_ready && req_valid;
  assign cap_en    = (st_q == ST_READ) && cnt_zero;

  always_comb begin
    cnt_load = 1'b0;
    cnt_val  = '0;
    case (st_q)
      ST_IDLE: if (req_valid) begin
        cnt_load = 1'b1;
        if (!req_write)     cnt_val = CW'(RD_LD);
        else if (prev_rd_q) cnt_val = CW'(TA_LD);
        else                cnt_val = CW'(WL_LD);
      end
      ST_TURN: if (cnt_zero) begin
        cnt_load = 1'b1;
        cnt_val  = CW'(WL_LD);
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q      <= ST_IDLE;
      prev_rd_q <= 1'b0;
      ce_n      <= 1'b1;
      oe_n      <= 1'b1;
      we_n      <= 1'b1;
      drv       <= 1'b0;
      done      <= 1'b0;
    end else begin
      done <= 1'b0;
      case (st_q)
        ST_IDLE: if (req_valid) begin
          if (!req_write) begin
            st_q <= ST_READ;
            ce_n <= 1'b0;
            oe_n <= 1'b0;
          end else if (prev_rd_q) begin
            st_q <= ST_TURN;
          end else begin
            st_q      <= ST_WRITE;
            ce_n      <= 1'b0;
            we_n      <= 1'b0;
            drv       <= 1'b1;
            prev_rd_q <= 1'b0;
          end
        end
        ST_TURN: if (cnt_zero) begin
          st_q      <= ST_WRITE;
          ce_n      <= 1'b0;
          we_n      <= 1'b0;
          drv       <= 1'b1;
          prev_rd_q <= 1'b0;
        end
        ST_READ: if (cnt_zero) begin
          st_q      <= ST_IDLE;
          ce_n      <= 1'b1;
          oe_n      <= 1'b1;
          done      <= 1'b1;
          prev_rd_q <= 1'b1;
        end
        ST_WRITE: if (cnt_zero) begin
          st_q <= ST_HOLD;
          ce_n <= 1'b1;
          we_n <= 1'b1;
        end
        ST_HOLD: begin
          st_q <= ST_IDLE;
          drv  <= 1'b0;
          done <= 1'b1;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  AST_WR_OE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    !we_n |-> oe_n);  // R4

  AST_DRIVE_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    drv |-> (!we_n || $past(!we_n)));  // R5

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);  // R3

  AST_TURN_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(we_n) |-> $past(oe_n, 2));  // R6

endmodule

// File: rtl/asram_dq_io.sv
module asram_dq_io #(
  parameter int AW = 19,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          lat_en,
  input  logic [AW-1:0] addr_in,
  input  logic [DW-1:0] wdata_in,
  input  logic          drv,
  input  logic          cap_en,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] rdata,
  inout  wire  [DW-1:0] dq
);

  logic [DW-1:0] wdata_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_addr <= '0;
      wdata_q  <= '0;
    end else if (lat_en) begin
      mem_addr <= addr_in;
      wdata_q  <= wdata_in;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      rdata <= '0;
    else if (cap_en) rdata <= dq;
  end

  assign dq = drv ? wdata_q : 'z;

  AST_WDATA_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    drv && $past(drv) |-> $stable(wdata_q));  // R7

endmodule

// File: rtl/asram_ctrl.sv
module asram_ctrl
  import asram_pkg::*;
#(
  parameter int AW     = 19,
  parameter int DW     = 16,
  parameter int CLK_NS = 4,
  parameter int T_RC   = 10,
  parameter int T_AA   = 10,
  parameter int T_OE   = 4,
  parameter int T_WC   = 10,
  parameter int T_WP   = 7,
  parameter int T_AW   = 7,
  parameter int T_DW   = 5,
  parameter int T_OHZ  = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic          req_write,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  output logic          rsp_done,
  output logic [DW-1:0] rsp_rdata,
  output logic [AW-1:0] sram_addr,
  inout  wire  [DW-1:0] sram_dq,
  output logic          sram_ce_n,
  output logic          sram_oe_n,
  output logic          sram_we_n
);

  // R8: wait lengths in whole cycles
  localparam int RD_CYC = imax(ns2cyc(T_RC, CLK_NS),
                               imax(ns2cyc(T_AA, CLK_NS), ns2cyc(T_OE, CLK_NS)));
  localparam int WL_CYC = imax(imax(ns2cyc(T_WP, CLK_NS), ns2cyc(T_DW, CLK_NS)),
                               imax(ns2cyc(T_AW, CLK_NS), ns2cyc(T_WC, CLK_NS) - 1));
  localparam int TA_CYC = ns2cyc(T_OHZ, CLK_NS);
  localparam int MAX_CYC = imax(RD_CYC, imax(WL_CYC, TA_CYC));
  localparam int CW      = $clog2(MAX_CYC + 1);

  logic          lat_en, cap_en, cnt_load, cnt_zero, drv;
  logic [CW-1:0] cnt_val;

  asram_wait_cnt #(.CW(CW)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (cnt_load),
    .load_val (cnt_val),
    .zero     (cnt_zero)
  );

  asram_seq #(
    .CW    (CW),
    .RD_LD (RD_CYC - 1),
    .WL_LD (WL_CYC - 1),
    .TA_LD (TA_CYC - 1)
  ) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_write (req_write),
    .cnt_zero  (cnt_zero),
    .req_ready (req_ready),
    .lat_en    (lat_en),
    .cap_en    (cap_en),
    .cnt_load  (cnt_load),
    .cnt_val   (cnt_val),
    .ce_n      (sram_ce_n),
    .oe_n      (sram_oe_n),
    .we_n      (sram_we_n),
    .drv       (drv),
    .done      (rsp_done)
  );

  asram_dq_io #(.AW(AW), .DW(DW)) u_io (
    .clk      (clk),
    .rst_n    (rst_n),
    .lat_en   (lat_en),
    .addr_in  (req_addr),
    .wdata_in (req_wdata),
    .drv      (drv),
    .cap_en   (cap_en),
    .mem_addr (sram_addr),
    .rdata    (rsp_rdata),
    .dq       (sram_dq)
  );

  AST_DONE_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_done |-> req_ready);  // R2

  AST_ADDR_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    !sram_ce_n && $past(!sram_ce_n) |-> $stable(sram_addr));  // R7

  AST_NO_BUS_FIGHT: assert property (@(posedge clk) disable iff (!rst_n)
    drv |-> sram_oe_n);  // R5

endmodule

// File: tb/asram_ctrl_tb.sv
module asram_ctrl_tb;

  localparam int PER = 4;
  localparam int T_RC = 10, T_AA = 10, T_OE = 4, T_WC = 10;
  localparam int T_WP = 7, T_AW = 7, T_DW = 5, T_OHZ = 4;

  function automatic int cyc(input int ns);
    int c;
    c = (ns + PER - 1) / PER;
    return (c < 1) ? 1 : c;
  endfunction
  function automatic int mx(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_write = 1'b0;
  logic [18:0] req_addr = '0;
  logic [15:0] req_wdata = '0;
  logic        req_ready, rsp_done;
  logic [15:0] rsp_rdata;
  logic [18:0] sram_addr;
  wire  [15:0] sram_dq;
  logic        sram_ce_n, sram_oe_n, sram_we_n;

  int vectors = 0;
  int miscomp = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  asram_ctrl u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .req_write (req_write),
    .req_addr  (req_addr),
    .req_wdata (req_wdata),
    .rsp_done  (rsp_done),
    .rsp_rdata (rsp_rdata),
    .sram_addr (sram_addr),
    .sram_dq   (sram_dq),
    .sram_ce_n (sram_ce_n),
    .sram_oe_n (sram_oe_n),
    .sram_we_n (sram_we_n)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    vectors++;
    if (!ok) begin
      miscomp++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // ---------------- behavioural memory ----------------
  logic [15:0] mem [int];
  logic [15:0] shadow [int];

  function automatic logic [15:0] init_pat(input logic [18:0] a);
    return a[15:0] ^ {a[18:16], 13'h0A5A};
  endfunction
  function automatic logic [15:0] mem_val(input logic [18:0] a);
    return mem.exists(int'(a)) ? mem[int'(a)] : init_pat(a);
  endfunction
  function automatic logic [15:0] shadow_val(input logic [18:0] a);
    return shadow.exists(int'(a)) ? shadow[int'(a)] : init_pat(a);
  endfunction

  logic        mdrv = 1'b0;
  logic [15:0] mout = '0;
  assign sram_dq = mdrv ? mout : 'z;

  int          rd_cnt = 0;
  bit          rd_act = 0;
  logic [18:0] raddr = '0;
  int          wlow = 0;
  logic [18:0] waddr = '0;
  logic [15:0] wdat = '0;
  logic        p_we = 1'b1;

  always @(negedge clk) begin
    bit hold_cyc;
    hold_cyc = (p_we == 1'b0) && (sram_we_n == 1'b1);
    // read side: corrupted data until the access time has passed,
    // output stays on for one cycle after output enable rises
    if (!sram_ce_n && !sram_oe_n && sram_we_n) begin
      if (rd_act && sram_addr == raddr) rd_cnt++;
      else begin rd_cnt = 1; raddr = sram_addr; end
      rd_act = 1;
      mdrv = 1'b1;
      mout = (rd_cnt * PER >= T_AA) ? mem_val(sram_addr) : ~mem_val(sram_addr);
    end else if (rd_act) begin
      rd_act = 0;
      mdrv = 1'b1;
    end else begin
      mdrv = 1'b0;
    end
    // R5: no overlap of memory output with controller drive window
    if (mdrv && (!sram_we_n || hold_cyc))
      chk(0, "R5 bus contention", {31'd0, sram_we_n}, 32'd1);
    // write side
    if (!sram_ce_n && !sram_we_n) begin
      if (!sram_oe_n) chk(0, "R4 oe low in write", 32'd0, 32'd1);
      if (wlow == 0) waddr = sram_addr;
      else begin
        if (sram_addr != waddr) chk(0, "R7 write address moved", sram_addr, waddr);
        if (sram_dq != wdat)    chk(0, "R7 write data moved", sram_dq, wdat);
      end
      wdat = sram_dq;
      wlow++;
    end else if (wlow > 0) begin
      chk(wlow * PER >= T_WP && wlow * PER >= T_DW && wlow * PER >= T_AW,
          "R8 write pulse/setup", wlow * PER, T_WP);
      chk(hold_cyc && sram_dq == wdat, "R5 hold cycle data", sram_dq, wdat);
      mem[int'(waddr)] = wdat;
      wlow = 0;
    end
    p_we = sram_we_n;
  end

  // ---------------- user-port tasks ----------------
  bit          last_rd = 0;
  logic [15:0] last_rdata = '0;
  int RD_CYC, WL_CYC, TA_CYC;

  task automatic do_op(input bit wr, input logic [18:0] a, input logic [15:0] d);
    int lat;
    int exp_lat;
    @(negedge clk);
    chk(rsp_done == 1'b0, "R3 done lasts one cycle", rsp_done, 0);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
    chk(req_ready == 1'b1, "R2 ready when idle", req_ready, 1);
    @(negedge clk);
    req_valid = 1'b0;
    req_addr  = 19'($urandom);
    req_wdata = 16'($urandom);
    req_write = 1'($urandom);
    lat = 1;
    while (!rsp_done && lat < 40) begin
      chk(req_ready == 1'b0, "R2 ready low while busy", req_ready, 0);
      @(negedge clk);
      lat++;
    end
    chk(req_ready == 1'b1, "R2 ready with done", req_ready, 1);
    if (!wr) exp_lat = RD_CYC + 1;
    else if (last_rd) exp_lat = WL_CYC + TA_CYC + 2;   // R6 turnaround gap
    else exp_lat = WL_CYC + 2;
    chk(lat == exp_lat, wr ? (last_rd ? "R6 write after read latency" : "R4 write latency")
                           : "R3 read latency", lat, exp_lat);
    if (wr) begin
      shadow[int'(a)] = d;
      chk(rsp_rdata == last_rdata, "R9 rdata kept on write", rsp_rdata, last_rdata);
    end else begin
      chk(rsp_rdata == shadow_val(a), "R10 read back", rsp_rdata, shadow_val(a));
      last_rdata = rsp_rdata;
    end
    last_rd = !wr;
  endtask

  // R6: a read-to-write switch shows a cycle with all enables high
  logic p_oe = 1'b1;
  bit   gap_watch = 0;
  always @(negedge clk) begin
    if (gap_watch) begin
      chk(sram_we_n == 1'b1, "R6 gap after read", sram_we_n, 1);
      gap_watch = 0;
    end
    if (p_oe == 1'b0 && sram_oe_n == 1'b1) gap_watch = 1;
    p_oe = sram_oe_n;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      miscomp++;
      vectors++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscomp);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    RD_CYC = mx(cyc(T_RC), mx(cyc(T_AA), cyc(T_OE)));
    WL_CYC = mx(mx(cyc(T_WP), cyc(T_DW)), mx(cyc(T_AW), cyc(T_WC) - 1));
    TA_CYC = cyc(T_OHZ);
    chk(RD_CYC == 3 && WL_CYC == 2 && TA_CYC == 1, "R8 derived counts",
        RD_CYC * 100 + WL_CYC * 10 + TA_CYC, 321);
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(req_ready == 1'b1 && rsp_done == 1'b0, "R1 reset handshake",
        {req_ready, rsp_done}, 2'b10);
    chk({sram_ce_n, sram_oe_n, sram_we_n} == 3'b111, "R1 reset enables",
        {sram_ce_n, sram_oe_n, sram_we_n}, 3'b111);
    rst_n = 1'b1;
    @(negedge clk);
    chk({sram_ce_n, sram_oe_n, sram_we_n} == 3'b111, "R1 idle enables",
        {sram_ce_n, sram_oe_n, sram_we_n}, 3'b111);

    // directed corners
    do_op(1, 19'h00000, 16'hFFFF);
    do_op(1, 19'h7FFFF, 16'h0000);
    do_op(0, 19'h00000, 16'h0);
    do_op(0, 19'h7FFFF, 16'h0);
    do_op(0, 19'h12345, 16'h0);          // never written
    do_op(1, 19'h12345, 16'hA5C3);       // write right after read
    do_op(1, 19'h12345, 16'h3C5A);       // back-to-back writes, last wins
    do_op(0, 19'h12345, 16'h0);
    do_op(0, 19'h12345, 16'h0);          // read-read
    do_op(1, 19'h00001, 16'h8001);

    // constrained random mix over a small address pool
    for (int i = 0; i < 200; i++) begin
      bit          wr;
      logic [18:0] a;
      wr = 1'($urandom);
      a  = 19'($urandom % 12) | (($urandom % 3 == 0) ? 19'h7FFF0 : 19'h0);
      do_op(wr, a, 16'($urandom));
    end

    repeat (4) @(negedge clk);
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscomp);
    $finish;
  end

endmodule